// File: doc/BRIEF.md
# Codec Control Serial Write Engine

This block turns a single register-write request into one frame on a three-wire, write-only control bus shared by two audio codecs. The bus has a shared clock line, a shared data line and one active-low select line for each codec. A request carries a codec index, a 5-bit register address and an 8-bit data byte. The engine builds a 16-bit frame and shifts it out most significant bit first. Every change on the bus lines is followed by a programmable settle interval.

A requester raises `req_i` while `ready_o` is high. The engine takes the request on that clock edge and runs the whole transfer without further help. It then reports completion with a one-cycle `done_o`. A request that names a codec with no select line is dropped and flagged on `err_o`. The settle interval `SETTLE_CYC` is counted in system clock cycles, so it can be set from microseconds in a product down to a few cycles in simulation.

Top module: `codec_cfg_writer`

## Requirements
- R1: The frame is 16 bits. Bits 15:14 hold the fixed chip address 2'b10, bit 13 is always 1, bits 12:8 hold `addr_i` and bits 7:0 hold `data_i`.
- R2: Frame bits leave on `sdata_o` most significant first, from bit 15 down to bit 0.
- R3: Each bit takes three phases of exactly `SETTLE_CYC` cycles each, in this order: `sclk_o` low with `sdata_o` unchanged, then `sdata_o` set to the bit with `sclk_o` still low, then `sclk_o` high.
- R4: In the first `SETTLE_CYC` cycles after the accepting edge, all four bus lines are high.
- R5: Index 0 drives `cs_no[0]` low and index 1 drives `cs_no[1]` low. The selected line falls `SETTLE_CYC` cycles after the accepting edge, one phase before the first clock-low phase. At most one select line is low at any time.
- R6: After the last clock-high phase, all four bus lines are high for `SETTLE_CYC` cycles. `done_o` is then high for exactly one cycle.
- R7: A request whose index is 2 or 3 is ignored. `err_o` is high for exactly the one cycle after the accepting edge, the bus lines stay high, `ready_o` stays high and no `done_o` follows.
- R8: `ready_o` is high only while idle. A request raised while busy is neither taken nor queued, and it does not disturb the running frame.
- R9: Out of reset and while idle, all bus lines are high, `ready_o` is 1, and `done_o` and `err_o` are 0.
- R10: `done_o` is high exactly 51*`SETTLE_CYC` cycles after the accepting edge, and `ready_o` returns one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, taken when ready_o is high |
| codec_i | input | 2 | Target codec index |
| addr_i | input | 5 | Codec register address |
| data_i | input | 8 | Codec register data |
| ready_o | output | 1 | Engine idle and able to take a request |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | One-cycle pulse for a rejected codec index |
| sclk_o | output | 1 | Serial clock line |
| sdata_o | output | 1 | Serial data line |
| cs_no | output | 2 | Per-codec select lines, active low |

## Verification
The bench treats the transfer as 51 phases of `SETTLE_CYC` cycles each. Phase k begins k*`SETTLE_CYC` cycles after the accepting edge. The bench samples all four bus lines on the falling clock edge in the first cycle of every phase and compares them with a table computed from the frame. `done_o` is due 51*`SETTLE_CYC` cycles after acceptance, `ready_o` one cycle later, and `err_o` in the single cycle after a rejected request. Each of these is sampled on the falling edge in exactly its cycle, and the neighbouring cycle is checked for the return to rest.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  localparam int unsigned CHIP_ID_W  = 2;
  localparam int unsigned CHIP_ID    = 2;
  localparam int unsigned WR_FLAG_W  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEL,
    ST_CLO,
    ST_DAT,
    ST_CHI,
    ST_POST,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/codec_cfg_frame.sv
module codec_cfg_frame
  import codec_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned FRAME_W = CHIP_ID_W + WR_FLAG_W + ADDR_W + DATA_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o
);

  localparam logic [CHIP_ID_W-1:0] ID_BITS = CHIP_ID_W'(CHIP_ID);

  // chip id | write flag | register | payload
  assign frame_o = {ID_BITS, 1'b1, addr_i, data_i};

endmodule

// File: rtl/codec_cfg_timer.sv
module codec_cfg_timer #(
  parameter int unsigned SETTLE_CYC = 5000,
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  // R4
  start_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned NUM_CODECS = 2,
  localparam int unsigned BIT_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic               ready_o,
  output logic               done_o,
  output logic               err_o,
  output logic               sel_act_o,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               sclk_o,
  output logic               sdata_o
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  seq_state_e         state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [BIT_W-1:0]   bit_q;
  logic [IDX_W-1:0]   idx_q;
  logic               sel_q, sclk_q, sdata_q, err_q;
  logic               accept, idx_ok;

  assign idx_ok  = idx_i < IDX_W'(NUM_CODECS);
  assign ready_o = state_q == ST_IDLE;
  assign accept  = req_i && ready_o;
  assign run_o   = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o  = state_q == ST_DONE;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      sel_q   <= 1'b0;
      sclk_q  <= 1'b1;
      sdata_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (idx_ok) begin
              state_q <= ST_PRE;
              shreg_q <= frame_i;
              idx_q   <= idx_i;
              bit_q   <= '0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_PRE: if (tick_i) begin
          state_q <= ST_SEL;
          sel_q   <= 1'b1;
        end
        ST_SEL: if (tick_i) begin
          state_q <= ST_CLO;
          sclk_q  <= 1'b0;
        end
        ST_CLO: if (tick_i) begin
          state_q <= ST_DAT;
          sdata_q <= shreg_q[FRAME_W-1];
        end
        ST_DAT: if (tick_i) begin
          state_q <= ST_CHI;
          sclk_q  <= 1'b1;
        end
        ST_CHI: if (tick_i) begin
          if (bit_q == LAST_BIT) begin
            state_q <= ST_POST;
            sel_q   <= 1'b0;
            sdata_q <= 1'b1;
          end else begin
            state_q <= ST_CLO;
            sclk_q  <= 1'b0;
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            bit_q   <= bit_q + 1'b1;
          end
        end
        ST_POST: if (tick_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_act_o = sel_q;
  assign sel_idx_o = idx_q;
  assign sclk_o    = sclk_q;
  assign sdata_o   = sdata_q;

  // R3
  data_moves_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && $changed(sdata_q)) |-> !sclk_q);

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_lines_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sclk_q && sdata_q && !sel_q));

  // R7
  err_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (ready_o && !sel_q));

  // R8
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> !ready_o);

  // R5
  clk_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_q |-> sel_q);

endmodule

// File: rtl/codec_cfg_csdec.sv
module codec_cfg_csdec #(
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned NUM_CODECS = 2
) (
  input  logic                  act_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [NUM_CODECS-1:0] cs_no
);

  for (genvar k = 0; k < NUM_CODECS; k++) begin : g_cs
    assign cs_no[k] = !(act_i && (idx_i == IDX_W'(k)));
  end

endmodule

// File: rtl/codec_cfg_writer.sv
module codec_cfg_writer
  import codec_cfg_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 5000,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned NUM_CODECS = 2,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [IDX_W-1:0]      codec_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic                  ready_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  sclk_o,
  output logic                  sdata_o,
  output logic [NUM_CODECS-1:0] cs_no
);

  localparam int unsigned FRAME_W = CHIP_ID_W + WR_FLAG_W + ADDR_W + DATA_W;

  logic [FRAME_W-1:0] frame;
  logic               tick, run, sel_act;
  logic [IDX_W-1:0]   sel_idx;

  codec_cfg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .addr_i (addr_i),
    .data_i (data_i),
    .frame_o(frame)
  );

  codec_cfg_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  codec_cfg_seq #(
    .FRAME_W   (FRAME_W),
    .IDX_W     (IDX_W),
    .NUM_CODECS(NUM_CODECS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .idx_i    (codec_i),
    .frame_i  (frame),
    .tick_i   (tick),
    .run_o    (run),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .sel_act_o(sel_act),
    .sel_idx_o(sel_idx),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o)
  );

  codec_cfg_csdec #(.IDX_W(IDX_W), .NUM_CODECS(NUM_CODECS)) u_csdec (
    .act_i(sel_act),
    .idx_i(sel_idx),
    .cs_no(cs_no)
  );

  // R5
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R9
  idle_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sclk_o && sdata_o && (&cs_no)));

endmodule

// File: tb/codec_cfg_writer_test.sv
module codec_cfg_writer_test;

  localparam int S = 3;
  localparam int NPH = 51;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] codec = '0;
  logic [4:0] addr = '0;
  logic [7:0] data = '0;
  logic       ready, done, err, sclk, sdata;
  logic [1:0] cs_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  codec_cfg_writer #(.SETTLE_CYC(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .codec_i(codec),
    .addr_i(addr), .data_i(data), .ready_o(ready), .done_o(done),
    .err_o(err), .sclk_o(sclk), .sdata_o(sdata), .cs_no(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_frame(input logic [4:0] a, input logic [7:0] d);
    return {2'b10, 1'b1, a, d};
  endfunction

  // {cs1, cs0, sclk, sdata}
  function automatic logic [3:0] exp_lines(input int c, input logic [15:0] f, input int p);
    logic [1:0] cs;
    int b, s;
    cs = (c == 0) ? 2'b10 : 2'b01;
    if (p == 0 || p == NPH - 1) return 4'b1111;
    if (p == 1) return {cs, 2'b11};
    b = (p - 2) / 3;
    s = (p - 2) % 3;
    if (s == 0) return {cs, 1'b0, (b == 0) ? 1'b1 : f[15 - (b - 1)]};
    if (s == 1) return {cs, 1'b0, f[15 - b]};
    return {cs, 1'b1, f[15 - b]};
  endfunction

  task automatic rest_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({cs_n, sclk, sdata} == 4'b1111, {tag, " lines"}, {cs_n, sclk, sdata}, 4'hf);
      chk(ready && !done && !err, {tag, " ready/done/err"}, {ready, done, err}, 3'b100);
    end
  endtask

  task automatic do_write(input int c, input logic [4:0] a, input logic [7:0] d, input bit poke);
    logic [15:0] f;
    logic [3:0] got, exp;
    f = mk_frame(a, d);
    @(negedge clk);
    req = 1'b1; codec = 2'(c); addr = a; data = d;
    @(negedge clk);
    req = 1'b0;
    chk(!err, "R7 no err on valid index", err, 0);
    for (int p = 0; p < NPH; p++) begin
      got = {cs_n, sclk, sdata};
      exp = exp_lines(c, f, p);
      // R1 R2 R3 R4 R5 R6
      chk(got == exp, $sformatf("R3 phase %0d lines (R1 R2 R4 R5 R6)", p), got, exp);
      chk(!ready && !done, "R8 busy flags", {ready, done}, 0);
      if (poke && p == 10) begin
        req = 1'b1; codec = 2'(1 - c); addr = ~a; data = ~d;
      end
      repeat (S) @(negedge clk);
    end
    chk(done && !ready, "R10 done due at 51*S", {done, ready}, 2'b10);
    chk({cs_n, sclk, sdata} == 4'b1111, "R6 lines high at done", {cs_n, sclk, sdata}, 4'hf);
    req = 1'b0;
    @(negedge clk);
    chk(!done && ready, "R10 ready one cycle after done", {done, ready}, 2'b01);
    if (poke) rest_check(3 * S + 4, "R8 busy request dropped");
  endtask

  task automatic do_bad(input int c);
    @(negedge clk);
    req = 1'b1; codec = 2'(c); addr = 5'h1f; data = 8'h00;
    @(negedge clk);
    req = 1'b0;
    chk(err && ready, "R7 err pulse", {err, ready}, 2'b11);
    chk({cs_n, sclk, sdata} == 4'b1111, "R7 lines idle", {cs_n, sclk, sdata}, 4'hf);
    rest_check(3 * S + 4, "R7 ignored");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    logic [4:0] a;
    logic [7:0] d;
    c = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R9
    chk(ready && !done && !err, "R9 reset flags", {ready, done, err}, 3'b100);
    chk({cs_n, sclk, sdata} == 4'b1111, "R9 reset lines", {cs_n, sclk, sdata}, 4'hf);
    rst_n = 1'b1;
    rest_check(4, "R9 idle");

    do_write(0, 5'h00, 8'h00, 1'b0);
    do_write(1, 5'h1f, 8'hff, 1'b0);
    do_write(0, 5'h15, 8'ha5, 1'b0);
    do_write(1, 5'h0a, 8'h5a, 1'b1);
    do_bad(2);
    do_bad(3);
    for (int i = 0; i < 12; i++) begin
      c = int'($urandom_range(0, 3));
      a = 5'($urandom);
      d = 8'($urandom);
      if (c < 2) do_write(c, a, d, ($urandom_range(0, 3) == 0));
      else do_bad(c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule